// File: doc/BRIEF.md
# Radix-4 Booth Multiplier, Signed or Unsigned

This block multiplies two 8-bit operands and returns a 16-bit product. A mode input chooses whether the operands are read as two's complement or as plain binary numbers. Both readings share one datapath.

The multiplier operand is recoded into radix-4 digits drawn from {-2,-1,0,+1,+2}. Each digit selects zero, one or two times the multiplicand, and a negative digit inverts that selection. All partial products, together with a row of increment bits that completes each negation, go through a chain of carry-save compressors. A two-level carry look-ahead adder then resolves the remaining sum and carry vectors.

Operands and mode are registered when a request strobe is seen. The product is registered one cycle later, so the block accepts a new request on every cycle.

Top module: `r4_booth_mult`

## Requirements
- R1: While reset (active low) is asserted, and right after it is released, `resValid` is 0 and `product` is 0.
- R2: A request presented with `reqValid`=1 before rising edge k produces its result after rising edge k+1. `resValid` is 1 for exactly one cycle for each request and is 0 otherwise.
- R3: With `signedMode`=0, `product` is the unsigned product of `opA` and `opB`, from 0 to 65025.
- R4: With `signedMode`=1, `product` is the 16-bit two's-complement product of `opA` and `opB` taken as signed values.
- R5: Extreme operands give exact results: signed 0x80*0x80 = 0x4000, signed 0x80*0x7F = 0xC080, signed 0xFF*0xFF = 0x0001, signed 0x80*0xFF = 0x0080, unsigned 0xFF*0xFF = 0xFE01.
- R6: If no request is presented, `product` keeps its last value, whatever the values on `opA`, `opB` and `signedMode`.
- R7: Requests on consecutive cycles each yield their own correct product, one result per cycle, in issue order.
- R8: The mode is captured together with the operands. A change on `signedMode` after the capture edge does not alter that request's result.
- R9: The multiplier is extended by two bits (sign bits when signed, zeros when unsigned) and recoded into W/2+1 digits, each of which selects at most one of the one-times or two-times multiples. In signed mode the top digit is always zero. Multipliers with isolated ones or alternating bits (0x01, 0x80, 0x55, 0xAA, 0x81, 0x7E) give correct products in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe; captures operands and mode |
| signedMode | input | 1 | 1: two's-complement operands, 0: unsigned |
| opA | input | 8 | Multiplicand |
| opB | input | 8 | Multiplier (the recoded operand) |
| resValid | output | 1 | Result strobe, two edges after the request |
| product | output | 16 | Registered 16-bit product |

## Verification
On every cycle, the assertions compare each newly loaded product with a behavioural multiply of the captured operands in the captured mode. They also check that the product and the operand registers hold when no load strobe is present, that every request produces a result strobe two edges later, and that the recoder never selects both multiples at once and leaves the top digit zero in signed mode. Other properties are visible only through the bench's scenarios at the ports: the reset values, the exhaustive operand sweep in each mode, streaming at one request per cycle, and that a mode flip right after capture is ignored.

// File: rtl/r4mul_pkg.sv
package r4mul_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadOps;   // capture operands and mode
    logic loadProd;  // capture the resolved product
  } ctlStrobes_t;

  // One radix-4 recoded digit: magnitude select plus sign
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } boothDigit_t;

  // grp = {upper, middle, lower} bits of an overlapping triplet
  function automatic boothDigit_t recodeGroup(input logic [2:0] grp);
    boothDigit_t dig;
    dig.one = grp[1] ^ grp[0];
    dig.two = (grp[2] & ~grp[1] & ~grp[0]) | (~grp[2] & grp[1] & grp[0]);
    dig.neg = grp[2] & ~(grp[1] & grp[0]);
    return dig;
  endfunction

endpackage

// File: rtl/r4mul_ctrl.sv
module r4mul_ctrl
  import r4mul_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output ctlStrobes_t strobes,
  output logic        resValid
);

  logic stageOneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageOneQ <= 1'b0;
      resValid  <= 1'b0;
    end else begin
      stageOneQ <= reqValid;
      resValid  <= stageOneQ;
    end
  end

  always_comb begin
    strobes.loadOps  = reqValid;
    strobes.loadProd = stageOneQ;
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> ##1 resValid); // R2

  AST_RESULT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(reqValid, 2)); // R2

endmodule

// File: rtl/r4mul_csa.sv
module r4mul_csa #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] inX,
  input  logic [WIDTH-1:0] inY,
  input  logic [WIDTH-1:0] inZ,
  output logic [WIDTH-1:0] sumV,
  output logic [WIDTH-1:0] carryV
);

  logic [WIDTH-1:0] majV;

  always_comb begin
    sumV   = inX ^ inY ^ inZ;
    majV   = (inX & inY) | (inX & inZ) | (inY & inZ);
    carryV = majV << 1;  // weight doubles; overflow past WIDTH is dropped (modular)
  end

endmodule

// File: rtl/r4mul_cla.sv
module r4mul_cla #(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] addA,
  input  logic [WIDTH-1:0] addB,
  output logic [WIDTH-1:0] sumOut
);

  localparam int NGRP = WIDTH / GROUP;

  // Carry into position n of a generate/propagate chain, flattened to two levels
  function automatic logic lookCarry(input logic [WIDTH-1:0] genV,
                                     input logic [WIDTH-1:0] propV,
                                     input logic cin, input int n);
    logic acc;
    logic term;
    acc = cin;
    for (int m = 0; m < WIDTH; m++) if (m < n) acc &= propV[m];
    for (int k = 0; k < WIDTH; k++) begin
      if (k < n) begin
        term = genV[k];
        for (int m = 0; m < WIDTH; m++) if (m > k && m < n) term &= propV[m];
        acc |= term;
      end
    end
    return acc;
  endfunction

  logic [WIDTH-1:0] bitG, bitP, bitC;
  logic [NGRP-1:0]  grpG, grpP, grpCin;

  assign bitG = addA & addB;
  assign bitP = addA ^ addB;

  for (genvar q = 0; q < NGRP; q++) begin : g_grp
    assign grpG[q] = lookCarry(WIDTH'(bitG[q*GROUP +: GROUP]),
                               WIDTH'(bitP[q*GROUP +: GROUP]), 1'b0, GROUP);
    assign grpP[q] = &bitP[q*GROUP +: GROUP];
    assign grpCin[q] = lookCarry(WIDTH'(grpG), WIDTH'(grpP), 1'b0, q);
    for (genvar j = 0; j < GROUP; j++) begin : g_bit
      assign bitC[q*GROUP + j] = lookCarry(WIDTH'(bitG[q*GROUP +: GROUP]),
                                           WIDTH'(bitP[q*GROUP +: GROUP]),
                                           grpCin[q], j);
    end
  end

  assign sumOut = bitP ^ bitC;

endmodule

// File: rtl/r4mul_dp.sv
module r4mul_dp
  import r4mul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobes_t   strobes,
  input  logic          signedMode,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  output logic [2*W-1:0] product
);

  localparam int PW    = 2 * W;     // product width
  localparam int XW    = W + 2;     // extended operand width
  localparam int NDIG  = W / 2 + 1; // recoded digits
  localparam int NROWS = NDIG + 1;  // partial products plus increment row
  localparam int NCSA  = NROWS - 2; // compressor stages

  logic [W-1:0]  aReg, bReg;
  logic          modeReg;
  logic [XW-1:0] aExt, bExt;
  logic [XW:0]   bPad;
  boothDigit_t   digitV [NDIG];
  logic [NDIG-1:0] negV;
  logic [PW-1:0] rowV [NROWS];
  logic [PW-1:0] incRow;
  logic [PW-1:0] csaSum [NCSA];
  logic [PW-1:0] csaCar [NCSA];
  logic [PW-1:0] resolved;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg    <= '0;
      bReg    <= '0;
      modeReg <= 1'b0;
    end else if (strobes.loadOps) begin
      aReg    <= opA;
      bReg    <= opB;
      modeReg <= signedMode;
    end
  end

  assign aExt = modeReg ? {{2{aReg[W-1]}}, aReg} : {2'b00, aReg};
  assign bExt = modeReg ? {{2{bReg[W-1]}}, bReg} : {2'b00, bReg};
  assign bPad = {bExt, 1'b0};

  for (genvar d = 0; d < NDIG; d++) begin : g_digit
    logic [XW-1:0] mulSel;
    logic [XW-1:0] ppRaw;
    assign digitV[d] = recodeGroup(bPad[2*d +: 3]);
    assign negV[d]   = digitV[d].neg;
    assign mulSel    = digitV[d].two ? (aExt << 1) :
                       digitV[d].one ? aExt : '0;
    assign ppRaw     = digitV[d].neg ? ~mulSel : mulSel;
    assign rowV[d]   = PW'($signed(ppRaw)) << (2 * d);

    AST_DIGIT_SINGLE_MULTIPLE: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({digitV[d].one, digitV[d].two})); // R9
  end

  always_comb begin
    incRow = '0;
    for (int d = 0; d < NDIG; d++) incRow[2*d] = negV[d];
  end
  assign rowV[NDIG] = incRow;

  for (genvar k = 0; k < NCSA; k++) begin : g_csa
    if (k == 0) begin : g_first
      r4mul_csa #(.WIDTH(PW)) i_csa (
        .inX(rowV[0]), .inY(rowV[1]), .inZ(rowV[2]),
        .sumV(csaSum[k]), .carryV(csaCar[k])
      );
    end else begin : g_next
      r4mul_csa #(.WIDTH(PW)) i_csa (
        .inX(csaSum[k-1]), .inY(csaCar[k-1]), .inZ(rowV[k+2]),
        .sumV(csaSum[k]), .carryV(csaCar[k])
      );
    end
  end

  r4mul_cla #(.WIDTH(PW), .GROUP(4)) i_cla (
    .addA(csaSum[NCSA-1]),
    .addB(csaCar[NCSA-1]),
    .sumOut(resolved)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) product <= '0;
    else if (strobes.loadProd) product <= resolved;
  end

  function automatic logic [PW-1:0] refMul(input logic [W-1:0] x,
                                           input logic [W-1:0] y,
                                           input logic sgn);
    logic signed [PW-1:0] sx, sy;
    sx = PW'($signed(x));
    sy = PW'($signed(y));
    if (sgn) return PW'(sx * sy);
    return PW'(x) * PW'(y);
  endfunction

  AST_UNSIGNED_PRODUCT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadProd && !modeReg) |=> product == $past(refMul(aReg, bReg, 1'b0))); // R3

  AST_SIGNED_PRODUCT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadProd && modeReg) |=> product == $past(refMul(aReg, bReg, 1'b1))); // R4

  AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadProd |=> $stable(product)); // R6

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadOps |=> $stable({aReg, bReg, modeReg})); // R8

  AST_SIGNED_TOP_DIGIT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    modeReg |-> (digitV[NDIG-1] == '0)); // R9

endmodule

// File: rtl/r4_booth_mult.sv
module r4_booth_mult
  import r4mul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          signedMode,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  output logic          resValid,
  output logic [2*W-1:0] product
);

  ctlStrobes_t strobes;

  r4mul_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .strobes(strobes), .resValid(resValid)
  );

  r4mul_dp #(.W(W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .signedMode(signedMode),
    .opA(opA), .opB(opB), .product(product)
  );

endmodule

// File: tb/test_r4_booth_mult.sv
module test_r4_booth_mult;

  localparam int W  = 8;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          signedMode = 1'b0;
  logic [W-1:0]  opA = '0;
  logic [W-1:0]  opB = '0;
  logic          resValid;
  logic [PW-1:0] product;

  int total = 0;
  int bad   = 0;

  logic [PW-1:0] exp1 = '0, exp2 = '0, lastExp = '0;
  logic          v1 = 1'b0, v2 = 1'b0;
  string         tag1 = "", tag2 = "";

  always #5 clk = ~clk;

  r4_booth_mult #(.W(W)) i_r4_booth_mult (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .signedMode(signedMode),
    .opA(opA), .opB(opB), .resValid(resValid), .product(product)
  );

  function automatic logic [PW-1:0] model(input logic [W-1:0] a,
                                          input logic [W-1:0] b,
                                          input logic sgn);
    int ia, ib;
    ia = sgn ? int'($signed(a)) : int'(a);
    ib = sgn ? int'($signed(b)) : int'(b);
    return PW'(ia * ib);
  endfunction

  task automatic checkVal(input string req, input logic [PW-1:0] act,
                          input logic [PW-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  // One cycle: check the result of the request issued two cycles ago, then drive
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic m, input logic vld, input string req);
    @(negedge clk);
    checkVal("R2 strobe", PW'(resValid), PW'(v2));
    if (v2) begin
      checkVal(tag2, product, exp2);
      lastExp = exp2;
    end else begin
      checkVal("R6 hold", product, lastExp);
    end
    v2 = v1; exp2 = exp1; tag2 = tag1;
    v1 = vld; exp1 = model(a, b, m); tag1 = req;
    reqValid = vld; opA = a; opB = b; signedMode = m;
  endtask

  task automatic flush();
    step(8'hA5, 8'h3C, 1'b1, 1'b0, "");
    step(8'h5A, 8'hC3, 1'b0, 1'b0, "");
    step(8'hFF, 8'h81, 1'b1, 1'b0, "");
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkVal("R1 strobe in reset", PW'(resValid), '0);
    checkVal("R1 product in reset", product, '0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 strobe after reset", PW'(resValid), '0);
    checkVal("R1 product after reset", product, '0);
  endtask

  task automatic testCorners();
    step(8'h80, 8'h80, 1'b1, 1'b1, "R5 -128*-128");
    step(8'h80, 8'h7F, 1'b1, 1'b1, "R5 -128*127");
    step(8'hFF, 8'hFF, 1'b1, 1'b1, "R5 -1*-1");
    step(8'h80, 8'hFF, 1'b1, 1'b1, "R5 -128*-1");
    step(8'hFF, 8'hFF, 1'b0, 1'b1, "R5 255*255");
    step(8'h00, 8'hFF, 1'b0, 1'b1, "R3 zero");
    step(8'h7F, 8'h7F, 1'b1, 1'b1, "R4 127*127");
    flush();
  endtask

  task automatic testPatterns();
    logic [W-1:0] pats [6] = '{8'h01, 8'h80, 8'h55, 8'hAA, 8'h81, 8'h7E};
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 6; p++)
        step(8'hB3, pats[p], 1'(m), 1'b1, "R9 pattern");
    flush();
  endtask

  task automatic testHold();
    step(8'h12, 8'h34, 1'b0, 1'b1, "R3 before hold");
    for (int i = 0; i < 5; i++)
      step(8'(i * 37 + 9), 8'(i * 71 + 3), 1'(i), 1'b0, "");
    // The idle steps check "R6 hold" against the last result
  endtask

  task automatic testModeSample();
    step(8'hFE, 8'h03, 1'b1, 1'b1, "R8 captured signed");
    step(8'hFE, 8'h03, 1'b0, 1'b0, "");
    step(8'hFE, 8'h03, 1'b0, 1'b1, "R8 captured unsigned");
    step(8'hFE, 8'h03, 1'b1, 1'b0, "");
    flush();
  endtask

  task automatic testExhaustive(input logic m);
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        step(8'(a), 8'(b), m, 1'b1, m ? "R4,R7 sweep" : "R3,R7 sweep");
    flush();
  endtask

  initial begin
    testReset();
    testCorners();
    testPatterns();
    testHold();
    testModeSample();
    testExhaustive(1'b0);
    testExhaustive(1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule